// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block collects up to 32 external interrupt pins. It turns each pin into a latched interrupt request according to that channel's own sense mode: low level, high level, rising edge, falling edge or both edges. Each pin is first brought into the block clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. A detection sets a per-channel status bit that software clears by writing 1. An enable mask with separate write-1-to-enable and write-1-to-disable locations gates each status bit onto its own interrupt output towards a parent controller.

Software reaches all state over a flat 32-bit register bus that has an address, write data, a write strobe and combinational read data. Besides the status and the mask, software can read the synchronized pin levels and four per-type views of the latched detections. Each channel has its own configuration word.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, all enables, detect status bits and configuration words are 0, and every `irq_out` bit is 0.
- R2: Reading offset 0x04 returns the enable mask. Writing 1 to bit n at 0x04 disables channel n, and writing 1 to bit n at 0x08 enables it. Zero bits written to either offset leave the mask unchanged.
- R3: Offset 0x100 holds the detect status. A detection on channel n sets bit n, and writing 1 to bit n clears it. In a level mode, clearing wins on the write cycle, and the bit sets again on the next cycle if the active level is still present. In an edge mode, a detection in the same cycle as the clear keeps the bit set.
- R4: Bits [5:0] of a channel's configuration word select its sense: 0x01 low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge, 0x0C both edges. Any other value, including 0, detects nothing.
- R5: Pins pass through two synchronizing flops. Offset 0x104 shows a pin change after two clock edges, and the detect bit is set on the third edge. An edge mode detects once per edge and not while the level holds.
- R6: Bit n of the per-type views is detect bit n ANDed with a mode test on channel n. At 0x108 the test is high level; at 0x10C, low level; at 0x110, rising or both edges; at 0x114, falling or both edges.
- R7: `irq_out[n]` equals detect bit n AND enable bit n, and offset 0x00 reads back the same vector.
- R8: The configuration word of channel n is at 0x180 + 4*n. All 32 bits read back as written, and bits [31:6] have no effect.
- R9: Reads of unmapped offsets, including configuration slots at or beyond NCH, return 0. Writes to them, and to offsets 0x00, 0x104 and 0x108 through 0x114, change no state. Register bits at or above NCH read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NCH | Asynchronous external interrupt pins |
| irq_out | output | NCH | Per-channel interrupt request to the parent controller |

## Verification
The bench aims at the clear-while-active case of a level channel. A design whose set and clear priority is reversed would hold the bit set through the clear, and one with no re-arm would leave the bit low although the level is still present. Edge channels are held at a steady level after a clear: a design that treated edges as levels would set the bit again, and one with the rising and falling compare swapped would fire on the wrong transition. The bench also checks configuration codes outside the five valid values, upper configuration bits and writes to read-only or unmapped offsets, where a loose decoder would detect something or corrupt the enable mask. Sampling is timed to the edge, so a missing or extra synchronizer stage shows up as a late or early status bit.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int unsigned OFS_REQ  = 32'h000;
  localparam int unsigned OFS_ENDIS = 32'h004;
  localparam int unsigned OFS_ENSET = 32'h008;
  localparam int unsigned OFS_DET  = 32'h100;
  localparam int unsigned OFS_MON  = 32'h104;
  localparam int unsigned OFS_VHI  = 32'h108;
  localparam int unsigned OFS_VLO  = 32'h10C;
  localparam int unsigned OFS_VRISE = 32'h110;
  localparam int unsigned OFS_VFALL = 32'h114;
  localparam int unsigned OFS_CFG  = 32'h180;

  localparam logic [5:0] SNS_LOW  = 6'h01;
  localparam logic [5:0] SNS_HIGH = 6'h02;
  localparam logic [5:0] SNS_FALL = 6'h04;
  localparam logic [5:0] SNS_RISE = 6'h08;
  localparam logic [5:0] SNS_BOTH = 6'h0C;

  function automatic int unsigned cfg_offset(int unsigned n);
    return OFS_CFG + 4 * n;
  endfunction

  function automatic logic is_edge_mode(logic [5:0] m);
    return (m == SNS_FALL) || (m == SNS_RISE) || (m == SNS_BOTH);
  endfunction

  function automatic logic sense_hit(logic [5:0] m, logic lvl, logic prev);
    case (m)
      SNS_LOW:  return ~lvl;
      SNS_HIGH: return lvl;
      SNS_FALL: return prev & ~lvl;
      SNS_RISE: return ~prev & lvl;
      SNS_BOTH: return prev ^ lvl;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic sees_rise(logic [5:0] m);
    return (m == SNS_RISE) || (m == SNS_BOTH);
  endfunction

  function automatic logic sees_fall(logic [5:0] m);
    return (m == SNS_FALL) || (m == SNS_BOTH);
  endfunction

endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] lvl,
  output logic [NCH-1:0] prev
);
  logic [NCH-1:0] stage1;
  logic [NCH-1:0] stage2;
  logic [NCH-1:0] stage3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= pin_in;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign lvl  = stage2;
  assign prev = stage3;
endmodule

// File: rtl/irqs_channel.sv
module irqs_channel
  import irqs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] wdata,
  input  logic        det_clr,
  input  logic        lvl,
  input  logic        prev,
  output logic [31:0] cfg,
  output logic        hit,
  output logic        det
);
  logic [5:0] mode;
  logic       edge_mode;
  logic       det_next;

  assign mode      = cfg[5:0];
  assign edge_mode = is_edge_mode(mode);
  assign hit       = sense_hit(mode, lvl, prev);

  always_comb begin
    det_next = (det & ~det_clr) | (hit & (~det_clr | edge_mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      det <= 1'b0;
    end else begin
      if (cfg_we) cfg <= wdata;
      det <= det_next;
    end
  end
endmodule

// File: rtl/irqs_enable.sv
module irqs_enable #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] bits,
  output logic [NCH-1:0] en
);
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;

  assign set_v = set_we ? bits : '0;
  assign clr_v = clr_we ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= (en & ~clr_v) | set_v;
  end
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irqs_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_we,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] irq_out
);
  localparam logic [AW-1:0] A_REQ   = AW'(OFS_REQ);
  localparam logic [AW-1:0] A_ENDIS = AW'(OFS_ENDIS);
  localparam logic [AW-1:0] A_ENSET = AW'(OFS_ENSET);
  localparam logic [AW-1:0] A_DET   = AW'(OFS_DET);
  localparam logic [AW-1:0] A_MON   = AW'(OFS_MON);
  localparam logic [AW-1:0] A_VHI   = AW'(OFS_VHI);
  localparam logic [AW-1:0] A_VLO   = AW'(OFS_VLO);
  localparam logic [AW-1:0] A_VRISE = AW'(OFS_VRISE);
  localparam logic [AW-1:0] A_VFALL = AW'(OFS_VFALL);

  function automatic logic [31:0] widen(logic [NCH-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  logic [NCH-1:0] lvl;
  logic [NCH-1:0] prev;
  logic [NCH-1:0] hit_vec;
  logic [NCH-1:0] det_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] det_clr;
  logic [NCH-1:0] cfg_sel;
  logic [NCH-1:0] v_hi, v_lo, v_rise, v_fall;
  logic [31:0]    cfg_all [NCH];
  logic           wr_det;

  irqs_sync #(.NCH(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .lvl   (lvl),
    .prev  (prev)
  );

  irqs_enable #(.NCH(NCH)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .set_we(bus_we && bus_addr == A_ENSET),
    .clr_we(bus_we && bus_addr == A_ENDIS),
    .bits  (bus_wdata[NCH-1:0]),
    .en    (en_q)
  );

  assign wr_det  = bus_we && bus_addr == A_DET;
  assign det_clr = wr_det ? bus_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg_sel[i] = (bus_addr == AW'(cfg_offset(i)));

    irqs_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (bus_we && cfg_sel[i]),
      .wdata  (bus_wdata),
      .det_clr(det_clr[i]),
      .lvl    (lvl[i]),
      .prev   (prev[i]),
      .cfg    (cfg_all[i]),
      .hit    (hit_vec[i]),
      .det    (det_q[i])
    );

    assign v_hi[i]   = det_q[i] & (cfg_all[i][5:0] == SNS_HIGH);
    assign v_lo[i]   = det_q[i] & (cfg_all[i][5:0] == SNS_LOW);
    assign v_rise[i] = det_q[i] & sees_rise(cfg_all[i][5:0]);
    assign v_fall[i] = det_q[i] & sees_fall(cfg_all[i][5:0]);
  end

  assign irq_out = det_q & en_q;

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_REQ)   bus_rdata = widen(irq_out);
    else if (bus_addr == A_ENDIS) bus_rdata = widen(en_q);
    else if (bus_addr == A_DET)   bus_rdata = widen(det_q);
    else if (bus_addr == A_MON)   bus_rdata = widen(lvl);
    else if (bus_addr == A_VHI)   bus_rdata = widen(v_hi);
    else if (bus_addr == A_VLO)   bus_rdata = widen(v_lo);
    else if (bus_addr == A_VRISE) bus_rdata = widen(v_rise);
    else if (bus_addr == A_VFALL) bus_rdata = widen(v_fall);
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg_sel[i]) bus_rdata = cfg_all[i];
      end
    end
  end
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic           bus_we,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] det_q,
  input logic [NCH-1:0] hit_vec,
  input logic [NCH-1:0] irq_out
);
  localparam logic [AW-1:0] C_ENDIS = AW'(32'h004);
  localparam logic [AW-1:0] C_ENSET = AW'(32'h008);
  localparam logic [AW-1:0] C_DET   = AW'(32'h100);

  // R2: enable bits written as 1 at the set offset are on one cycle later
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_ENSET) |=>
      ((en_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // R2: enable bits written as 1 at the disable offset are off one cycle later
  assert_enable_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_ENDIS) |=>
      ((en_q & $past(bus_wdata[NCH-1:0])) == '0));

  // R3: a detect bit only rises when its channel reported a hit
  assert_det_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ~$past(det_q) & ~$past(hit_vec)) == '0));

  // R3: bits cleared by software stay clear unless a hit was present
  assert_det_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_DET) |=>
      ((det_q & $past(bus_wdata[NCH-1:0]) & ~$past(hit_vec)) == '0));

  // R7: a request only goes out for an enabled, detected channel
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~(en_q & det_q)) == '0));
endmodule

bind irq_sense_ctrl irqs_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .en_q     (en_q),
  .det_q    (det_q),
  .hit_vec  (hit_vec),
  .irq_out  (irq_out)
);

// File: tb/irq_sense_ctrl_test.sv
module irq_sense_ctrl_test;
  localparam int NCH = 8;
  localparam int AW  = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_we = 1'b0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] irq_out;

  int checks = 0;
  int errors = 0;

  irq_sense_ctrl #(.NCH(NCH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int unsigned a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] bitof(int n);
    return 32'h1 << n;
  endfunction

  task automatic rd(int unsigned a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic pins(logic [NCH-1:0] v, int wait_edges);
    @(negedge clk);
    pin_in = v;
    repeat (wait_edges) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 irq_out", 32'(irq_out), 0);
    rd(32'h004, d); check("R1 enable", d, 0);
    rd(32'h100, d); check("R1 detect", d, 0);
    rd(32'h180, d); check("R1 cfg0", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(32'h008, 32'h05);  rd(32'h004, d); check("R2 set", d, 32'h05);
    wr(32'h004, 32'h01);  rd(32'h004, d); check("R2 clear", d, 32'h04);
    wr(32'h008, 32'h00);  rd(32'h004, d); check("R2 zero set", d, 32'h04);
    wr(32'h004, 32'h00);  rd(32'h004, d); check("R2 zero clear", d, 32'h04);
    wr(32'h008, 32'hFFFF_FF00); rd(32'h004, d); check("R9 bits above NCH", d, 32'h04);
    wr(32'h004, 32'h04);
  endtask

  task automatic t_high_level();
    logic [31:0] d;
    wr(32'h184, 32'h02);
    pins(8'h02, 1);
    @(negedge clk);
    rd(32'h104, d); check("R5 monitor after two edges", d & bitof(1), bitof(1));
    rd(32'h100, d); check("R5 no detect after two edges", d & bitof(1), 0);
    @(negedge clk);
    rd(32'h100, d); check("R5 detect on third edge", d & bitof(1), bitof(1));
    rd(32'h108, d); check("R6 high view", d & bitof(1), bitof(1));
    rd(32'h110, d); check("R6 rise view not high", d & bitof(1), 0);
    check("R7 irq gated off", 32'(irq_out), 0);
    wr(32'h008, bitof(1));
    check("R7 irq on", 32'(irq_out), bitof(1));
    rd(32'h000, d); check("R7 request reg", d, bitof(1));
    wr(32'h100, bitof(1));
    rd(32'h100, d); check("R3 level clear wins", d & bitof(1), 0);
    @(negedge clk);
    rd(32'h100, d); check("R3 level re-sets", d & bitof(1), bitof(1));
    pins(8'h00, 3);
    wr(32'h100, bitof(1));
    @(negedge clk);
    rd(32'h100, d); check("R3 stays clear", d & bitof(1), 0);
    check("R7 irq off", 32'(irq_out), 0);
    wr(32'h004, bitof(1));
  endtask

  task automatic t_low_level();
    logic [31:0] d;
    wr(32'h188, 32'h01);
    @(negedge clk);
    rd(32'h100, d); check("R4 low level", d & bitof(2), bitof(2));
    rd(32'h10C, d); check("R6 low view", d & bitof(2), bitof(2));
    wr(32'h188, 32'h00);
    wr(32'h100, bitof(2));
    @(negedge clk);
    rd(32'h100, d); check("R4 code 0 no detect", d & bitof(2), 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(32'h18C, 32'h08);
    wr(32'h190, 32'h04);
    wr(32'h194, 32'h0C);
    pins(8'h38, 3);
    rd(32'h100, d); check("R4 rise sets ch3/ch5 only", d & 32'h38, 32'h28);
    rd(32'h110, d); check("R6 rise view", d & 32'h38, 32'h28);
    rd(32'h114, d); check("R6 fall view", d & 32'h38, 32'h20);
    wr(32'h100, 32'h38);
    repeat (3) @(negedge clk);
    rd(32'h100, d); check("R5 edge not level", d & 32'h38, 0);
    pins(8'h00, 3);
    rd(32'h100, d); check("R4 fall sets ch4/ch5 only", d & 32'h38, 32'h30);
    wr(32'h100, 32'h38);
  endtask

  task automatic t_bad_codes();
    logic [31:0] d;
    wr(32'h198, 32'hABCD_0003);
    rd(32'h198, d); check("R8 cfg readback", d, 32'hABCD_0003);
    pins(8'h40, 3);
    pins(8'h00, 3);
    rd(32'h100, d); check("R4 invalid code", d & bitof(6), 0);
    wr(32'h198, 32'hFFFF_FFC0);
    pins(8'h40, 3);
    rd(32'h100, d); check("R8 upper bits inert", d & bitof(6), 0);
    rd(32'h104, d); check("R5 monitor level", d, bitof(6));
    pins(8'h00, 3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(32'h008, 32'h80);
    wr(32'h00C, 32'hFF);
    wr(32'h000, 32'hFF);
    wr(32'h104, 32'hFF);
    rd(32'h004, d); check("R9 enable untouched", d, 32'h80);
    rd(32'h00C, d); check("R9 unmapped read", d, 0);
    wr(32'h180 + 4 * NCH, 32'h02);
    rd(32'h180 + 4 * NCH, d); check("R9 cfg beyond NCH", d, 0);
    rd(32'h100, d); check("R9 status untouched", d, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_high_level();
    t_low_level();
    t_edges();
    t_bad_codes();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule